// File: doc/BRIEF.md
# Multiplexed System Bus Request Master

This block sits between a processor core and a shared multiplexed address/data system bus. The core hands it one request at a time: a read or a write of either a single datum (1 to 8 bytes inside one doubleword) or a whole 32-byte cache line. The block then runs the bus side of that request. It places the address and a command code on the AD and command buses with the valid-out strobe, and holds them until the external agent signals that it can take the transaction. Write data follows in one or more data beats. For a read, the block turns the bus around: it drops its drive enable, raises the release line, and gathers the response beats that the agent marks with valid-in.

The AD bus width is a parameter, 32 or 64 bits. A line always moves as consecutive beats of the bus width. On a 32-bit bus, a single datum whose bytes straddle the word boundary goes out as two back-to-back transfers. Only one request is in flight at a time. The core-side ready stays low from the accept cycle until the completion pulse. When the bus is idle and the agent asks for the bus, the block gives it up through the same release line until the agent withdraws the request.

Top module: `sysbus_master`

## Requirements
- R1: An address phase drives valid_out high with cmd_out[7]=0, cmd_out[6]=write flag, cmd_out[5]=line flag, cmd_out[4:3]=0 and cmd_out[2:0]=byte count minus one (0 for a line). ad_out carries the address, zero-extended, with its low three bits as the byte offset.
- R2: A line transfer uses a 32-byte-aligned address and moves 256/BUS_W beats. Beat k carries bits [k*BUS_W +: BUS_W] of the line.
- R3: On a 32-bit bus, a single datum with offset below 4 and offset+count above 4 is sent as two transfers. The first has the original offset and count 4-offset. The second has offset 4 and count offset+count-4. The caller keeps offset+count at or below 8.
- R4: The address phase repeats unchanged on every cycle where the matching ready input (wr_rdy for writes, rd_rdy for reads) is low. It ends after the first cycle where that input is high.
- R5: The cycle after a read address phase is accepted, bus_release is high and ad_oe and valid_out are low. This holds until the last response beat has been sampled. ad_oe returns high in the next cycle.
- R6: A response beat is taken on each cycle where valid_in is high during the slave period. It is stored at the lane of R2 for a line, or at lane address bit 2 on a 32-bit bus, or lane 0 on a 64-bit bus. All other bits of rd_line read zero.
- R7: A write data beat drives valid_out high with cmd_out[7]=1, cmd_out[6]=1 only on the final beat of that transfer, and cmd_out[5:0]=0. A single datum takes its data from the lane chosen as in R6.
- R8: req_ready is high only in the idle state while ext_rqst is low. It stays low from the accept cycle until the completion pulse.
- R9: With ext_rqst high in the idle state, the next cycle shows bus_release high and ad_oe and req_ready low, and any core request is left pending. One cycle after ext_rqst falls, the bus is idle and driven again.
- R10: done is a single-cycle pulse in the cycle after the last beat of the last transfer of a request.
- R11: While reset is held, valid_out, bus_release, done and req_ready are low and ad_oe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted this cycle when valid is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line | input | 1 | 1 = 32-byte line, 0 = single datum |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 4 | Single datum byte count, 1 to 8 |
| req_wdata | input | 256 | Write line, byte i at bits 8*i |
| done | output | 1 | Request completed |
| rd_line | output | 256 | Assembled read data |
| ad_out | output | BUS_W | AD bus value driven |
| ad_in | input | BUS_W | AD bus value received |
| ad_oe | output | 1 | Drive enable for AD and command buses |
| cmd_out | output | 8 | Command bus value |
| valid_out | output | 1 | Valid command or data driven |
| valid_in | input | 1 | Agent drives valid data |
| rd_rdy | input | 1 | Agent can take a read |
| wr_rdy | input | 1 | Agent can take a write |
| ext_rqst | input | 1 | Agent asks for the bus |
| bus_release | output | 1 | Bus handed to the agent |

## Verification
The first address phase appears one cycle after the accept edge. Each later phase, data beat or response capture advances on the edge that samples the enabling input. done and the restored drive enable show up one cycle after the last beat. The bench drives inputs and samples outputs at the falling edge. It walks a per-cycle expectation that moves forward only on the edge where the design must move. Stalled address phases, the turnaround, the completion cycle and the cycle after it are therefore each compared at the exact cycle they are due.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;
  localparam int CMD_W  = 8;
  localparam int LINE_W = 256;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_WDATA = 3'd2,
    ST_RSLV  = 3'd3,
    ST_EXT   = 3'd4
  } bus_state_t;

  function automatic logic [CMD_W-1:0] cmd_addr_code(input logic wr, input logic line,
                                                     input logic [3:0] cnt);
    logic [2:0] c;
    c = line ? 3'd0 : 3'(cnt - 4'd1);
    return {1'b0, wr, line, 2'b00, c};
  endfunction

  function automatic logic [CMD_W-1:0] cmd_data_code(input logic last);
    return {1'b1, last, 6'b000000};
  endfunction
endpackage

// File: rtl/sysbus_split.sv
module sysbus_split #(
  parameter int BUS_W = 64
) (
  input  logic [2:0] off_in,
  input  logic [3:0] size_in,
  input  logic       line_in,
  output logic       two_parts,
  output logic [2:0] off0,
  output logic [3:0] cnt0,
  output logic [2:0] off1,
  output logic [3:0] cnt1
);
  logic [4:0] end_pos;
  assign end_pos = {2'b00, off_in} + {1'b0, size_in};

  generate
    if (BUS_W == 32) begin : g_narrow
      always_comb begin
        two_parts = 1'b0;
        off0      = off_in;
        cnt0      = size_in;
        off1      = 3'd4;
        cnt1      = 4'd0;
        if (!line_in && !off_in[2] && (end_pos > 5'd4)) begin
          two_parts = 1'b1;
          cnt0      = 4'd4 - {1'b0, off_in};
          cnt1      = 4'(end_pos - 5'd4);
        end
      end
    end else begin : g_wide
      always_comb begin
        two_parts = 1'b0;
        off0      = off_in;
        cnt0      = size_in;
        off1      = 3'd4;
        cnt1      = 4'd0;
      end
    end
  endgenerate
endmodule

// File: rtl/sysbus_beat_ctr.sv
module sysbus_beat_ctr #(
  parameter int MAX_BEATS = 4,
  localparam int CW = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW:0]   limit,
  output logic [CW-1:0] count,
  output logic          is_last
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr || inc)  cnt_q <= cnt_d;
  end

  assign count   = cnt_q;
  assign is_last = ({1'b0, cnt_q} == (limit - 1'b1));
endmodule

// File: rtl/sysbus_rd_capture.sv
module sysbus_rd_capture #(
  parameter int BUS_W  = 64,
  parameter int LINE_W = 256,
  localparam int LANES = LINE_W / BUS_W,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BUS_W-1:0]  din,
  output logic [LINE_W-1:0] line
);
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [BUS_W-1:0] lane_q;
      logic             lane_en;
      assign lane_en = clr || (we && (idx == IDX_W'(g)));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lane_q <= '0;
        else if (lane_en) lane_q <= clr ? '0 : din;
      end
      assign line[g*BUS_W +: BUS_W] = lane_q;
    end
  endgenerate
endmodule

// File: rtl/sysbus_master.sv
module sysbus_master #(
  parameter int BUS_W  = 64,
  parameter int ADDR_W = 32,
  localparam int LINE_W = sysbus_pkg::LINE_W,
  localparam int CMD_W  = sysbus_pkg::CMD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_line,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [LINE_W-1:0] req_wdata,
  output logic              done,
  output logic [LINE_W-1:0] rd_line,
  output logic [BUS_W-1:0]  ad_out,
  input  logic [BUS_W-1:0]  ad_in,
  output logic              ad_oe,
  output logic [CMD_W-1:0]  cmd_out,
  output logic              valid_out,
  input  logic              valid_in,
  input  logic              rd_rdy,
  input  logic              wr_rdy,
  input  logic              ext_rqst,
  output logic              bus_release
);
  import sysbus_pkg::*;

  localparam int LINE_BEATS = LINE_W / BUS_W;
  localparam int IDX_W      = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  bus_state_t         st_q, st_d;
  logic               wr_q, line_q, part_q, part_d, done_q, done_d;
  logic [ADDR_W-1:0]  addr_q;
  logic [3:0]         size_q;
  logic [LINE_W-1:0]  wdata_q;
  logic               accept, ld_en;

  // split of the single datum into bus-sized transfers
  logic       two_parts;
  logic [2:0] off0, off1;
  logic [3:0] cnt0, cnt1;

  sysbus_split #(.BUS_W(BUS_W)) u_split (
    .off_in    (addr_q[2:0]),
    .size_in   (size_q),
    .line_in   (line_q),
    .two_parts (two_parts),
    .off0      (off0),
    .cnt0      (cnt0),
    .off1      (off1),
    .cnt1      (cnt1)
  );

  logic [2:0]        cur_off;
  logic [3:0]        cur_cnt;
  logic [ADDR_W-1:0] part_addr;
  assign cur_off   = part_q ? off1 : off0;
  assign cur_cnt   = part_q ? cnt1 : cnt0;
  assign part_addr = line_q ? {addr_q[ADDR_W-1:5], 5'b00000}
                            : {addr_q[ADDR_W-1:3], cur_off};

  // beat counting
  localparam int CW = (LINE_BEATS > 1) ? $clog2(LINE_BEATS) : 1;
  logic          beat_clr, beat_inc, beat_last;
  logic [CW:0]   beat_lim;
  logic [CW-1:0] beat_cnt;
  assign beat_lim = line_q ? (CW+1)'(LINE_BEATS) : (CW+1)'(1);
  assign beat_clr = (st_q == ST_ADDR);
  assign beat_inc = (st_q == ST_WDATA) || ((st_q == ST_RSLV) && valid_in);

  sysbus_beat_ctr #(.MAX_BEATS(LINE_BEATS)) u_beats (
    .clk     (clk),
    .rst_n   (rst_s),
    .clr     (beat_clr),
    .inc     (beat_inc),
    .limit   (beat_lim),
    .count   (beat_cnt),
    .is_last (beat_last)
  );

  // lane selection
  logic [IDX_W-1:0] lane_single, lane;
  generate
    if (BUS_W == 32) begin : g_lane32
      assign lane_single = IDX_W'(part_addr[2]);
    end else begin : g_lane64
      assign lane_single = '0;
    end
  endgenerate
  assign lane = line_q ? IDX_W'(beat_cnt) : lane_single;

  sysbus_rd_capture #(.BUS_W(BUS_W), .LINE_W(LINE_W)) u_cap (
    .clk   (clk),
    .rst_n (rst_s),
    .clr   (accept),
    .we    ((st_q == ST_RSLV) && valid_in),
    .idx   (lane),
    .din   (ad_in),
    .line  (rd_line)
  );

  // next state
  logic rdy_match, xfer_end;
  assign req_ready = rst_s && (st_q == ST_IDLE) && !ext_rqst;
  assign accept    = req_valid && req_ready;
  assign ld_en     = accept;
  assign rdy_match = wr_q ? wr_rdy : rd_rdy;
  assign xfer_end  = beat_inc && beat_last;

  always_comb begin
    st_d   = st_q;
    part_d = part_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ext_rqst) begin
          st_d = ST_EXT;
        end else if (req_valid && rst_s) begin
          st_d   = ST_ADDR;
          part_d = 1'b0;
        end
      end
      ST_ADDR: begin
        if (rdy_match) st_d = wr_q ? ST_WDATA : ST_RSLV;
      end
      ST_WDATA, ST_RSLV: begin
        if (xfer_end) begin
          if (!part_q && two_parts) begin
            st_d   = ST_ADDR;
            part_d = 1'b1;
          end else begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end
      end
      ST_EXT: begin
        if (!ext_rqst) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= ST_IDLE;
      part_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      part_q <= part_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      wr_q    <= 1'b0;
      line_q  <= 1'b0;
      addr_q  <= '0;
      size_q  <= 4'd1;
      wdata_q <= '0;
    end else if (ld_en) begin
      wr_q    <= req_write;
      line_q  <= req_line;
      addr_q  <= req_addr;
      size_q  <= req_size;
      wdata_q <= req_wdata;
    end
  end

  // bus outputs
  always_comb begin
    ad_out  = '0;
    cmd_out = '0;
    unique case (st_q)
      ST_ADDR: begin
        ad_out[ADDR_W-1:0] = part_addr;
        cmd_out            = cmd_addr_code(wr_q, line_q, cur_cnt);
      end
      ST_WDATA: begin
        ad_out  = wdata_q[lane*BUS_W +: BUS_W];
        cmd_out = cmd_data_code(beat_last);
      end
      default: begin
        ad_out  = '0;
        cmd_out = '0;
      end
    endcase
  end

  assign valid_out   = (st_q == ST_ADDR) || (st_q == ST_WDATA);
  assign bus_release = (st_q == ST_RSLV) || (st_q == ST_EXT);
  assign ad_oe       = !bus_release;
  assign done        = done_q;
endmodule

// File: rtl/sysbus_master_chk.sv
module sysbus_master_chk #(
  parameter int BUS_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             done,
  input logic [BUS_W-1:0] ad_out,
  input logic             ad_oe,
  input logic [7:0]       cmd_out,
  input logic             valid_out,
  input logic             rd_rdy,
  input logic             wr_rdy,
  input logic             ext_rqst,
  input logic             bus_release
);
  logic addr_ph, addr_rdy;
  assign addr_ph  = valid_out && !cmd_out[7];
  assign addr_rdy = cmd_out[6] ? wr_rdy : rd_rdy;

  // R4: stalled address phase repeats unchanged
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ph && !addr_rdy |=> addr_ph && $stable(ad_out) && $stable(cmd_out));

  // R5: read accepted hands the bus over next cycle
  p_read_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ph && !cmd_out[6] && rd_rdy |=> bus_release && !ad_oe && !valid_out);

  // R5: never drive while released
  p_no_drive_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |-> !ad_oe && !valid_out);

  // R8: one request at a time
  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R9: agent bus request while idle
  p_ext_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rqst && ad_oe && !valid_out && !done |=> bus_release);

  // R10: completion is a single pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind sysbus_master sysbus_master_chk #(.BUS_W(BUS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .done        (done),
  .ad_out      (ad_out),
  .ad_oe       (ad_oe),
  .cmd_out     (cmd_out),
  .valid_out   (valid_out),
  .rd_rdy      (rd_rdy),
  .wr_rdy      (wr_rdy),
  .ext_rqst    (ext_rqst),
  .bus_release (bus_release)
);

// File: tb/sysbus_master_bench.sv
module sysbus_lane #(
  parameter int BUS_W = 64
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_vec,
  output int   n_bad,
  output logic fin
);
  localparam int NB_LINE = 256 / BUS_W;

  logic             req_valid, req_ready, req_write, req_line, done;
  logic [31:0]      req_addr;
  logic [3:0]       req_size;
  logic [255:0]     req_wdata, rd_line;
  logic [BUS_W-1:0] ad_out, ad_in;
  logic             ad_oe, valid_out, valid_in, rd_rdy, wr_rdy, ext_rqst, bus_release;
  logic [7:0]       cmd_out;

  sysbus_master #(.BUS_W(BUS_W), .ADDR_W(32)) u_sysbus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_line(req_line), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .done(done), .rd_line(rd_line),
    .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .cmd_out(cmd_out),
    .valid_out(valid_out), .valid_in(valid_in), .rd_rdy(rd_rdy), .wr_rdy(wr_rdy),
    .ext_rqst(ext_rqst), .bus_release(bus_release)
  );

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (bus %0d) actual=%h expected=%h", tag, BUS_W, act, exp);
    end
  endtask

  task automatic run_txn(input bit wr, input bit blk, input logic [31:0] addr,
                         input int size);
    logic [31:0]      pa [2];
    int               pc [2];
    int               np, nb, pi, bi, k, off, fin_pos, lim;
    bit               ph, end_seen, stalled;
    logic [255:0]     wd, exp_line;
    logic [7:0]       ec;
    logic [BUS_W-1:0] d, ea;
    off = int'(addr[2:0]);
    fin_pos = off + size;
    if (blk) begin
      np = 1; pa[0] = {addr[31:5], 5'b0}; pc[0] = 0; nb = NB_LINE;
    end else if (BUS_W == 32 && off < 4 && fin_pos > 4) begin
      np = 2; pa[0] = addr; pc[0] = 4 - off;
      pa[1] = {addr[31:3], 3'b100}; pc[1] = fin_pos - 4; nb = 1;
    end else begin
      np = 1; pa[0] = addr; pc[0] = size; nb = 1;
    end
    for (int i = 0; i < 8; i++) wd[32*i +: 32] = $urandom;
    req_write = wr; req_line = blk; req_addr = addr; req_size = 4'(size);
    req_wdata = wd; req_valid = 1'b1;
    chk(req_ready === 1'b1, "R8 ready when idle", 256'(req_ready), 256'd1);
    @(negedge clk);
    req_valid = 1'b0;
    exp_line = '0; pi = 0; bi = 0; ph = 0; end_seen = 0; stalled = 0; lim = 0;
    while (!end_seen && lim < 400) begin
      lim++;
      valid_in = 1'b0;
      rd_rdy = ($urandom % 3) != 0;
      wr_rdy = ($urandom % 3) != 0;
      chk(req_ready === 1'b0 && done === 1'b0, "R8 busy blocks new request",
          256'({req_ready, done}), 256'd0);
      k = blk ? bi : ((BUS_W == 32) ? int'(pa[pi][2]) : 0);
      if (!ph) begin
        ec = {1'b0, wr, blk, 2'b00, blk ? 3'd0 : 3'(pc[pi] - 1)};
        ea = '0; ea[31:0] = pa[pi];
        chk(valid_out === 1'b1 && ad_oe === 1'b1 && cmd_out === ec,
            stalled ? "R4 held command" : "R1 address phase command", 256'(cmd_out), 256'(ec));
        chk(ad_out === ea, blk ? "R2 aligned line address" :
            (np == 2 ? "R3 split part address" : "R1 address value"), 256'(ad_out), 256'(ea));
        if (wr ? wr_rdy : rd_rdy) begin ph = 1; bi = 0; stalled = 0; end
        else stalled = 1;
      end else if (wr) begin
        ec = {1'b1, (bi == nb - 1), 6'b0};
        chk(valid_out === 1'b1 && cmd_out === ec, "R7 write beat command",
            256'(cmd_out), 256'(ec));
        chk(ad_out === wd[k*BUS_W +: BUS_W], blk ? "R2 line write beat" : "R7 single write lane",
            256'(ad_out), 256'(wd[k*BUS_W +: BUS_W]));
        bi++;
        if (bi == nb) begin
          if (pi + 1 < np) begin pi++; ph = 0; end else end_seen = 1;
        end
      end else begin
        chk(bus_release === 1'b1 && ad_oe === 1'b0 && valid_out === 1'b0,
            "R5 slave state during read", 256'({bus_release, ad_oe, valid_out}), 256'b100);
        if ($urandom % 2) begin
          valid_in = 1'b1;
          d = BUS_W'({$urandom, $urandom});
          ad_in = d;
          exp_line[k*BUS_W +: BUS_W] = d;
          bi++;
          if (bi == nb) begin
            if (pi + 1 < np) begin pi++; ph = 0; end else end_seen = 1;
          end
        end
      end
      @(negedge clk);
    end
    valid_in = 1'b0;
    chk(done === 1'b1, "R10 done after last beat", 256'(done), 256'd1);
    chk(ad_oe === 1'b1 && bus_release === 1'b0, "R5 drive restored",
        256'({ad_oe, bus_release}), 256'b10);
    if (!wr) chk(rd_line === exp_line, "R6 assembled read data", rd_line, exp_line);
    @(negedge clk);
    chk(done === 1'b0, "R10 done lasts one cycle", 256'(done), 256'd0);
  endtask

  task automatic ext_test();
    ext_rqst = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_line = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(bus_release === 1'b1 && ad_oe === 1'b0 && req_ready === 1'b0 && valid_out === 1'b0,
          "R9 bus granted to agent", 256'({bus_release, ad_oe, req_ready, valid_out}), 256'b1000);
      @(negedge clk);
    end
    ext_rqst = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    chk(bus_release === 1'b0 && ad_oe === 1'b1 && req_ready === 1'b1 && valid_out === 1'b0,
        "R9 bus taken back", 256'({bus_release, ad_oe, req_ready, valid_out}), 256'b0110);
  endtask

  initial begin
    int off, sz;
    n_vec = 0; n_bad = 0; fin = 1'b0;
    req_valid = 0; req_write = 0; req_line = 0; req_addr = '0; req_size = 4'd1;
    req_wdata = '0; ad_in = '0; valid_in = 0; rd_rdy = 0; wr_rdy = 0; ext_rqst = 0;
    @(negedge clk); @(negedge clk);
    chk(valid_out === 1'b0 && bus_release === 1'b0 && done === 1'b0 &&
        req_ready === 1'b0 && ad_oe === 1'b1, "R11 reset outputs",
        256'({valid_out, bus_release, done, req_ready, ad_oe}), 256'b00001);
    wait (rst_n === 1'b1);
    repeat (3) @(negedge clk);
    run_txn(1, 0, 32'h0000_1003, 4);
    run_txn(0, 0, 32'h0000_2000, 8);
    run_txn(0, 0, 32'h0000_2006, 2);
    run_txn(1, 0, 32'h0000_3004, 4);
    run_txn(0, 1, 32'h0000_4013, 1);
    run_txn(1, 1, 32'h0000_5040, 1);
    ext_test();
    for (int n = 0; n < 40; n++) begin
      off = $urandom % 8;
      sz  = 1 + ($urandom % (8 - off));
      run_txn($urandom % 2, ($urandom % 4) == 0, {$urandom} & 32'hFFFF_FFF8 | 32'(off), sz);
    end
    ext_test();
    fin = 1'b1;
  end
endmodule

module sysbus_master_bench;
  logic clk, rst_n;
  int   v64, b64, v32, b32, cyc, total_v, total_b;
  logic f64, f32;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  sysbus_lane #(.BUS_W(64)) u_lane64 (.clk(clk), .rst_n(rst_n), .n_vec(v64), .n_bad(b64), .fin(f64));
  sysbus_lane #(.BUS_W(32)) u_lane32 (.clk(clk), .rst_n(rst_n), .n_vec(v32), .n_bad(b32), .fin(f32));

  initial begin
    void'($urandom(32'd4817));
    rst_n = 1'b0;
    cyc = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    while (!(f64 === 1'b1 && f32 === 1'b1) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    total_v = v64 + v32;
    total_b = b64 + b32;
    if (cyc >= 100000) begin
      total_v++;
      total_b++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 100000);
    end
    $display("== %0d vectors applied, %0d miscompares ==", total_v, total_b);
    $finish;
  end
endmodule